// File: doc/BRIEF.md
# Switch Address Table Command Unit

This block holds a small table of MAC addresses for a switch control plane and services commands on it through a 16-bit register window. Each entry is keyed by a database ID together with a 48-bit MAC and carries a port membership vector and a state code. Software sets up its operands first: the database ID, the MAC split across three registers, and a data word that packs the state and the port vector. It then writes an operation code to the command register.

Four operations are provided. A load creates or updates one entry. A load whose state is zero removes the matching entry instead. Get-next walks upward through the addresses of one database ID. A flush removes every dynamic entry of one database ID and leaves static ones in place. The table is searched one entry per clock, and a busy flag reports that a command is still running. While busy is set, the unit ignores every register write.

Top module: `atuCmdUnit`

## Requirements
- R1: After reset, every register reads zero, and the table is empty. A get-next on any database ID returns state 0.
- R2: The register map is as follows. Offset 0x01 holds the database ID in its low 4 bits. Offset 0x0C holds the state in bits 3:0 and the port vector in bits 11:4, and bits 15:12 read zero. Offsets 0x0D, 0x0E and 0x0F hold MAC bits 47:32, 31:16 and 15:0. While the unit is idle, a write to any of these registers reads back at once.
- R3: A write to offset 0x0B whose bits 14:12 are 3 (load), 4 (get-next) or 6 (flush) starts a command. Bit 15 of 0x0B then reads 1 from the next cycle and for at most 18 cycles (table depth plus two). Any other code starts nothing.
- R4: While bit 15 of 0x0B is set, writes to all registers are ignored.
- R5: A load with a nonzero state either creates the entry for (database ID, MAC) with the given ports and state, or overwrites the ports and state of that entry if it already exists.
- R6: A load with state 0 removes the entry whose key matches. If no entry matches, the table is left unchanged.
- R7: Get-next finds, within the same database ID, the entry with the smallest MAC that is strictly greater than the MAC registers. It loads that entry's MAC, ports and state into the registers. If no such entry exists, the data register reads 0.
- R8: A get-next whose starting MAC is all ones returns the lowest MAC of that database ID.
- R9: Flush removes every entry of the given database ID whose state is neither 0xE (static unicast) nor 0xF (static multicast). It does not touch static entries or entries of other database IDs.
- R10: A load of a new key into a table that already holds 16 entries leaves the table unchanged and sets bit 11 of 0x0B. That bit stays set until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for read and write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr, combinational |

## Verification
A lost, stale or misplaced table entry shows up in the next get-next walk over its database ID. The walk either returns a MAC or port vector that differs from the model, or it ends too early or too late, so every table-changing command is followed by full walks of all database IDs. A search tracker that is not cleared between commands would corrupt the very next command's result. A control counter that fails to stop shows up as a busy flag that stays set beyond depth plus two cycles, or as a register write that wrongly takes effect during a command.

// File: rtl/atuPkg.sv
package atuPkg;
  localparam int MAC_W   = 48;
  localparam int PORT_W  = 8;
  localparam int STATE_W = 4;

  localparam logic [3:0] A_FID  = 4'h1;
  localparam logic [3:0] A_OP   = 4'hB;
  localparam logic [3:0] A_DATA = 4'hC;
  localparam logic [3:0] A_MACH = 4'hD;
  localparam logic [3:0] A_MACM = 4'hE;
  localparam logic [3:0] A_MACL = 4'hF;

  localparam logic [2:0] OP_LOAD  = 3'd3;
  localparam logic [2:0] OP_NEXT  = 3'd4;
  localparam logic [2:0] OP_FLUSH = 3'd6;

  localparam logic [STATE_W-1:0] ST_FREE      = 4'h0;
  localparam logic [STATE_W-1:0] ST_UC_STATIC = 4'hE;
  localparam logic [STATE_W-1:0] ST_MC_STATIC = 4'hF;

  typedef struct packed {
    logic       start;
    logic       scan;
    logic       commit;
    logic [2:0] op;
  } ctrlStrobeT;

  function automatic logic isStatic(input logic [STATE_W-1:0] s);
    return (s == ST_UC_STATIC) || (s == ST_MC_STATIC);
  endfunction
endpackage

// File: rtl/atuCtrl.sv
module atuCtrl
  import atuPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opWr,
  input  logic [2:0]       opCode,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output ctrlStrobeT       strobe
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DONE} stateT;
  stateT state;
  logic [2:0] curOp;
  logic accept;

  assign accept = (state == S_IDLE) && opWr &&
                  (opCode == OP_LOAD || opCode == OP_NEXT || opCode == OP_FLUSH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
      curOp <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_SCAN;
          idx   <= '0;
          curOp <= opCode;
        end
        S_SCAN: begin
          if (idx == IDX_W'(DEPTH - 1)) state <= S_DONE;
          else idx <= idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign strobe.start  = accept;
  assign strobe.scan   = (state == S_SCAN);
  assign strobe.commit = (state == S_DONE);
  assign strobe.op     = curOp;

  logic [7:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= 8'(DEPTH + 2)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy); // R3
endmodule

// File: rtl/atuData.sv
module atuData
  import atuPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FID_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrOk,
  input  logic [3:0]       regAddr,
  input  logic [15:0]      regWrData,
  output logic [15:0]      regRdData,
  input  logic             busy,
  input  logic [IDX_W-1:0] idx,
  input  ctrlStrobeT       strobe
);
  logic [FID_W-1:0]   fidReg;
  logic [MAC_W-1:0]   macReg;
  logic [PORT_W-1:0]  portReg;
  logic [STATE_W-1:0] stReg;
  logic               fullFlag;

  logic               tValid [DEPTH];
  logic [FID_W-1:0]   tFid   [DEPTH];
  logic [MAC_W-1:0]   tMac   [DEPTH];
  logic [PORT_W-1:0]  tPort  [DEPTH];
  logic [STATE_W-1:0] tSt    [DEPTH];

  logic             mHit, fHit, bHit;
  logic [IDX_W-1:0] mIdx, fIdx, bIdx;
  logic [MAC_W-1:0] bMac;

  logic entHit, keyHit, wrapAll, nextCand;
  assign entHit   = tValid[idx] && (tFid[idx] == fidReg);
  assign keyHit   = entHit && (tMac[idx] == macReg);
  assign wrapAll  = &macReg;
  assign nextCand = entHit && (wrapAll || tMac[idx] > macReg) &&
                    (!bHit || tMac[idx] < bMac);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fidReg <= '0; macReg <= '0; portReg <= '0; stReg <= '0; fullFlag <= 1'b0;
      mHit <= 1'b0; fHit <= 1'b0; bHit <= 1'b0;
      mIdx <= '0; fIdx <= '0; bIdx <= '0; bMac <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tValid[i] <= 1'b0; tFid[i] <= '0; tMac[i] <= '0; tPort[i] <= '0; tSt[i] <= '0;
      end
    end else begin
      if (wrOk) begin
        case (regAddr)
          A_FID:  fidReg <= regWrData[FID_W-1:0];
          A_DATA: begin
            stReg   <= regWrData[STATE_W-1:0];
            portReg <= regWrData[STATE_W +: PORT_W];
          end
          A_MACH: macReg[47:32] <= regWrData;
          A_MACM: macReg[31:16] <= regWrData;
          A_MACL: macReg[15:0]  <= regWrData;
          default: ;
        endcase
      end
      if (strobe.start) begin
        fullFlag <= 1'b0;
        mHit <= 1'b0; fHit <= 1'b0; bHit <= 1'b0;
      end
      if (strobe.scan) begin
        case (strobe.op)
          OP_LOAD: begin
            if (keyHit) begin mHit <= 1'b1; mIdx <= idx; end
            if (!tValid[idx] && !fHit) begin fHit <= 1'b1; fIdx <= idx; end
          end
          OP_NEXT: if (nextCand) begin
            bHit <= 1'b1; bIdx <= idx; bMac <= tMac[idx];
          end
          OP_FLUSH: if (entHit && !isStatic(tSt[idx])) tValid[idx] <= 1'b0;
          default: ;
        endcase
      end
      if (strobe.commit) begin
        case (strobe.op)
          OP_LOAD: begin
            if (mHit) begin
              if (stReg == ST_FREE) tValid[mIdx] <= 1'b0;
              else begin tPort[mIdx] <= portReg; tSt[mIdx] <= stReg; end
            end else if (stReg != ST_FREE) begin
              if (fHit) begin
                tValid[fIdx] <= 1'b1; tFid[fIdx] <= fidReg; tMac[fIdx] <= macReg;
                tPort[fIdx]  <= portReg; tSt[fIdx] <= stReg;
              end else fullFlag <= 1'b1;
            end
          end
          OP_NEXT: begin
            if (bHit) begin
              macReg <= bMac; portReg <= tPort[bIdx]; stReg <= tSt[bIdx];
            end else begin
              portReg <= '0; stReg <= ST_FREE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      A_FID:   regRdData = 16'(fidReg);
      A_OP:    regRdData = {busy, 3'b000, fullFlag, 11'b0};
      A_DATA:  regRdData = 16'({portReg, stReg});
      A_MACH:  regRdData = macReg[47:32];
      A_MACM:  regRdData = macReg[31:16];
      A_MACL:  regRdData = macReg[15:0];
      default: regRdData = '0;
    endcase
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(fidReg)); // R4
  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(strobe.commit && strobe.op == OP_LOAD)); // R10
  AST_FULL_CLEAR_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> !fullFlag); // R10
endmodule

// File: rtl/atuCmdUnit.sv
module atuCmdUnit
  import atuPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FID_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [3:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData
);
  localparam int IDX_W = $clog2(DEPTH);
  logic busy, wrOk;
  logic [IDX_W-1:0] idx;
  ctrlStrobeT strobe;

  assign wrOk = regWr && !busy;

  atuCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .opWr(wrOk && regAddr == A_OP), .opCode(regWrData[14:12]),
    .busy(busy), .idx(idx), .strobe(strobe)
  );

  atuData #(.DEPTH(DEPTH), .FID_W(FID_W)) u_data (
    .clk(clk), .rstN(rstN), .wrOk(wrOk), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .busy(busy), .idx(idx), .strobe(strobe)
  );
endmodule

// File: tb/atuCmdUnit_tb.sv
module atuCmdUnit_tb;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] regWrData = '0, regRdData;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  atuCmdUnit #(.DEPTH(DEPTH)) u_dut (.clk(clk), .rstN(rstN), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData));

  bit        mV [DEPTH];
  int        mF [DEPTH];
  logic [47:0] mM [DEPTH];
  logic [7:0]  mP [DEPTH];
  logic [3:0]  mS [DEPTH];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic waitIdle(output int cyc);
    logic [15:0] v;
    cyc = 0;
    rd(4'hB, v);
    while (v[15] && cyc < 100) begin
      @(negedge clk); cyc++; rd(4'hB, v);
    end
  endtask

  task automatic doCmd(input logic [2:0] code, input string tag);
    logic [15:0] v; int cyc;
    wr(4'hB, {1'b0, code, 12'h0});
    rd(4'hB, v);
    chk(v[15] == 1'b1, {tag, " R3 busy set"}, v[15], 1);
    waitIdle(cyc);
    chk(cyc >= 1 && cyc <= DEPTH + 2, {tag, " R3 busy length"}, cyc, DEPTH + 1);
  endtask

  task automatic setMac(input logic [47:0] m);
    wr(4'hD, m[47:32]); wr(4'hE, m[31:16]); wr(4'hF, m[15:0]);
  endtask

  task automatic getMac(output logic [47:0] m);
    logic [15:0] a, b, c;
    rd(4'hD, a); rd(4'hE, b); rd(4'hF, c);
    m = {a, b, c};
  endtask

  function automatic int modelCount();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (mV[i]) n++;
    return n;
  endfunction

  function automatic int modelNext(input int f, input logic [47:0] cur, input bit wrap);
    int best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mV[i] && mF[i] == f && (wrap || mM[i] > cur) && (best < 0 || mM[i] < mM[best]))
        best = i;
    return best;
  endfunction

  task automatic load(input int f, input logic [47:0] m, input logic [7:0] p,
                      input logic [3:0] s, input string tag);
    int hit = -1, fr = -1; bit expFull = 0; logic [15:0] v;
    wr(4'h1, 16'(f)); setMac(m); wr(4'hC, {4'h0, p, s});
    doCmd(3'd3, tag);
    for (int i = 0; i < DEPTH; i++) begin
      if (mV[i] && mF[i] == f && mM[i] == m) hit = i;
      if (!mV[i] && fr < 0) fr = i;
    end
    if (hit >= 0) begin
      if (s == 0) mV[hit] = 0; else begin mP[hit] = p; mS[hit] = s; end
    end else if (s != 0) begin
      if (fr >= 0) begin mV[fr] = 1; mF[fr] = f; mM[fr] = m; mP[fr] = p; mS[fr] = s; end
      else expFull = 1;
    end
    rd(4'hB, v);
    chk(v[11] == expFull, {tag, " R10 full flag"}, v[11], expFull);
  endtask

  task automatic next(input int f, input logic [47:0] start, input string tag);
    int e; logic [15:0] d; logic [47:0] m;
    e = modelNext(f, start, &start);
    wr(4'h1, 16'(f)); setMac(start);
    doCmd(3'd4, tag);
    rd(4'hC, d); getMac(m);
    if (e < 0) chk(d == 16'h0, {tag, " R7 end of walk"}, d, 0);
    else begin
      chk(d == {4'h0, mP[e], mS[e]}, {tag, " R7 data"}, d, {4'h0, mP[e], mS[e]});
      chk(m == mM[e], {tag, " R7 mac"}, m, mM[e]);
    end
  endtask

  task automatic walk(input int f, input string tag);
    logic [47:0] cur = 48'h0;
    for (int k = 0; k <= DEPTH; k++) begin
      int e = modelNext(f, cur, 0);
      next(f, cur, tag);
      if (e < 0) break;
      cur = mM[e];
    end
  endtask

  task automatic walkAll(input string tag);
    for (int f = 0; f < 4; f++) walk(f, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v; int cyc;
    for (int i = 0; i < DEPTH; i++) mV[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    foreach (v[i]) ;
    rd(4'hB, v); chk(v == 0, "R1 op reg", v, 0);
    rd(4'h1, v); chk(v == 0, "R1 fid reg", v, 0);
    rd(4'hC, v); chk(v == 0, "R1 data reg", v, 0);
    rd(4'hD, v); chk(v == 0, "R1 mac hi", v, 0);
    walkAll("R1 empty");
    // R2 register layout
    wr(4'hD, 16'h0102); wr(4'hE, 16'h0304); wr(4'hF, 16'h0506);
    begin logic [47:0] m; getMac(m); chk(m == 48'h010203040506, "R2 mac bytes", m, 48'h010203040506); end
    wr(4'hC, 16'hFFFF); rd(4'hC, v); chk(v == 16'h0FFF, "R2 data mask", v, 16'h0FFF);
    wr(4'h1, 16'h00F7); rd(4'h1, v); chk(v == 16'h0007, "R2 fid width", v, 16'h0007);
    // R3 unknown code starts nothing
    for (int c = 0; c < 8; c++) begin
      if (c == 3 || c == 4 || c == 6) continue;
      wr(4'hB, 16'(c << 12)); rd(4'hB, v);
      chk(v[15] == 0, "R3 unknown code", v, 0);
    end
    // R5 population
    for (int i = 0; i < 12; i++) begin
      logic [3:0] s = (i % 4 == 0) ? 4'hE : (i == 5 ? 4'hF : 4'((i % 7) + 1));
      load(i % 3, 48'h020000000001 + 48'(((i * 5) % 12) * 257), 8'(i * 17 + 3), s, "R5 load");
    end
    walkAll("R5 walk");
    // R8 wrap from all ones
    for (int f = 0; f < 3; f++) next(f, 48'hFFFFFFFFFFFF, "R8 wrap");
    // R5 overwrite existing key
    load(1, mM[1], 8'h5A, 4'h3, "R5 update");
    walk(1, "R5 update walk");
    // R6 purge, and purge of absent key
    load(1, mM[4], 8'h00, 4'h0, "R6 purge");
    load(2, 48'h0A0A0A0A0A0A, 8'h00, 4'h0, "R6 purge absent");
    walkAll("R6 walk");
    // R4 writes during busy ignored
    wr(4'h1, 16'h0000);
    wr(4'hB, 16'h4000);
    wr(4'h1, 16'h0005);
    wr(4'hC, 16'h0ABC);
    waitIdle(cyc);
    rd(4'h1, v); chk(v == 16'h0000, "R4 fid held", v, 0);
    rd(4'hC, v); chk(v[11:0] != 12'hABC, "R4 data held", v, 0);
    // R9 flush fid 0
    wr(4'h1, 16'h0000);
    doCmd(3'd6, "R9 flush");
    for (int i = 0; i < DEPTH; i++)
      if (mV[i] && mF[i] == 0 && mS[i] != 4'hE && mS[i] != 4'hF) mV[i] = 0;
    walkAll("R9 walk");
    // R10 fill table then overflow
    for (int k = 0; k < 40 && modelCount() < DEPTH; k++)
      load(2, 48'h030000000000 + 48'(k * 3), 8'(k), 4'h5, "R10 fill");
    load(2, 48'h0F0000000000, 8'h11, 4'h7, "R10 overflow");
    rd(4'hB, v); chk(v[11] == 1, "R10 sticky set", v[11], 1);
    wr(4'h1, 16'h0002); wr(4'hB, 16'h0000);
    rd(4'hB, v); chk(v[11] == 1, "R10 sticky on ignored code", v[11], 1);
    walk(2, "R10 table unchanged");
    rd(4'hB, v); chk(v[11] == 0, "R10 cleared by command", v[11], 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule